// File: doc/BRIEF.md
# Channel Command Stream Decoder

This block sits behind a channel's command FIFO and turns its stream of 32-bit words into actions. It takes words through a valid/ready handshake and reads the first word of each command as a header. A 4-bit opcode in the header decides which fields are extracted and how many payload words follow. Each payload word is then either emitted as one register-write request, carrying a target offset, the data and the current class, or passed on as a gather address.

Commands that carry no payload come out as one-cycle events with a kind code, an offset and a data field. These are class changes, immediate writes, restart jumps and the lock sub-commands of the extended opcode. An unrecognised opcode raises a one-cycle error pulse and is treated as a header with no payload. The write output is a single register slot. When that slot is full and downstream does not take it, the decoder stops accepting words.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After synchronous reset, inReady is 1, wrValid, evtValid, gathValid and errPulse are 0, and the current class is 0.
- R2: An incrementing write header (opcode 0x1, offset in bits 27:16, count in bits 15:0) is followed by exactly that many payload words. The n-th word (from 0) is written to offset+n. With a count of 0, the next word is a header.
- R3: A non-incrementing write header (opcode 0x2, same fields as R2) writes every one of its count payload words to the same offset.
- R4: A masked write header (opcode 0x3, base offset in bits 27:16, mask in bits 15:0) takes one payload word per set mask bit k. It writes to base+k in ascending k. A zero mask takes no payload.
- R5: A class-set header (opcode 0x0, class in bits 15:6, offset in bits 27:16, mask in bits 5:0) emits an event of kind 0 with evtData = class and evtOffset = offset. All later writes carry that class on wrClass. A nonzero mask takes payload words exactly as in R4.
- R6: An immediate header (opcode 0x4) emits an event of kind 1 with evtOffset = bits 27:16 and evtData = bits 15:0 zero-extended. It takes no payload.
- R7: A restart header (opcode 0x5) emits an event of kind 2 with evtData = header shifted left by 4. It takes no payload.
- R8: A gather header (opcode 0x6, offset 27:16, insert flag 15, type flag 14, count 13:0) produces no write. Its single following word produces one gather pulse that carries those fields and the word as the address.
- R9: An extended header (opcode 0xE) with sub-opcode 0 in bits 27:24 emits an event of kind 3, and with sub-opcode 1 an event of kind 4. In both, evtData is bits 7:0. Any other sub-opcode emits kind 5 with evtData = the whole header.
- R10: A header with any other opcode raises errPulse for exactly one cycle, takes no payload, and produces no write or event.
- R11: While wrValid is 1 and wrReady is 0, inReady is 0 and wrOffset, wrData and wrClass hold their values.
- R12: Events, gather pulses and errPulse appear in the cycle after the word that caused them is accepted. wrValid rises in the cycle after a payload word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Command word offered |
| inReady | output | 1 | Decoder accepts a word this cycle |
| inWord | input | 32 | Command word |
| wrValid | output | 1 | Register-write request valid |
| wrReady | input | 1 | Downstream takes the write |
| wrOffset | output | 12 | Target register offset |
| wrData | output | 32 | Write data |
| wrClass | output | 10 | Class active for the write |
| evtValid | output | 1 | One-cycle event strobe |
| evtKind | output | 3 | Event kind code |
| evtOffset | output | 12 | Event offset (class-set and immediate only, else 0) |
| evtData | output | 32 | Event data field |
| gathValid | output | 1 | One-cycle gather request strobe |
| gathOffset | output | 12 | Gather offset field |
| gathInsert | output | 1 | Gather insert flag |
| gathType | output | 1 | Gather type flag |
| gathCount | output | 14 | Gather word count |
| gathAddr | output | 32 | Gather address word |
| errPulse | output | 1 | Unknown opcode strobe |

## Verification
Two things can share one clock edge. The write slot can hand its last payload write downstream at the same edge that accepts the next header. A stalled slot can also release at the edge where the waiting payload word is finally taken. The bench provokes the first with back-to-back commands and wrReady held high. It provokes the second by holding wrReady low while a further payload word waits, then raising it. In both cases it judges the full ordered log of writes and events captured at the ports, so a lost, doubled or reordered write shows up, and a header misread as payload shows up too.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W     = 32;
  localparam int OP_W       = 4;
  localparam int SUB_W      = 4;
  localparam int OFF_W      = 12;
  localparam int CLASS_W    = 10;
  localparam int CNT_W      = 16;
  localparam int MASK_W     = 16;
  localparam int CLS_MASK_W = 6;
  localparam int GCNT_W     = 14;
  localparam int IDX_W      = 8;
  localparam int KIND_W     = 3;
  localparam int MIDX_W     = $clog2(MASK_W);

  typedef enum logic [OP_W-1:0] {
    OP_SETCLASS = 4'h0,
    OP_INCR     = 4'h1,
    OP_NONINCR  = 4'h2,
    OP_MASK     = 4'h3,
    OP_IMM      = 4'h4,
    OP_RESTART  = 4'h5,
    OP_GATHER   = 4'h6,
    OP_EXT      = 4'hE
  } opcode_t;

  typedef enum logic [1:0] {
    PAY_INCR, PAY_FIXED, PAY_MASK, PAY_GATHER
  } payMode_t;

  typedef enum logic [KIND_W-1:0] {
    EVT_CLASS       = 3'd0,
    EVT_IMM         = 3'd1,
    EVT_RESTART     = 3'd2,
    EVT_LOCK_ACQ    = 3'd3,
    EVT_LOCK_REL    = 3'd4,
    EVT_EXT_UNKNOWN = 3'd5
  } evtKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     hdrLoad;
    logic     classLoad;
    logic     payStep;
    logic     gathAddr;
    logic     evtFire;
    evtKind_t evtKind;
    logic     errFire;
    payMode_t payMode;
  } ctlStrb_t;

  function automatic logic [CNT_W-1:0] popCnt(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MASK_W; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [MIDX_W-1:0] lowIdx(input logic [MASK_W-1:0] m);
    logic [MIDX_W-1:0] k;
    k = '0;
    for (int i = MASK_W - 1; i >= 0; i--) if (m[i]) k = MIDX_W'(i);
    return k;
  endfunction
endpackage

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   hdrOp,
  input  logic [SUB_W-1:0]  hdrSub,
  input  logic [MASK_W-1:0] hdrLow,
  input  logic              wrValid,
  input  logic              wrReady,
  output logic              inReady,
  output ctlStrb_t          strb
);
  logic [CNT_W-1:0] remCnt, loadCnt;
  payMode_t         mode, loadMode;
  logic             accept, busy;

  assign inReady = !wrValid || wrReady;
  assign accept  = inValid && inReady;
  assign busy    = remCnt != '0;

  always_comb begin
    strb         = '0;
    strb.payMode = mode;
    loadCnt      = '0;
    loadMode     = PAY_INCR;
    if (accept && busy) begin
      if (mode == PAY_GATHER) strb.gathAddr = 1'b1;
      else                    strb.payStep  = 1'b1;
    end else if (accept) begin
      strb.hdrLoad = 1'b1;
      case (opcode_t'(hdrOp))
        OP_SETCLASS: begin
          strb.classLoad = 1'b1;
          strb.evtFire   = 1'b1;
          strb.evtKind   = EVT_CLASS;
          loadMode       = PAY_MASK;
          loadCnt        = popCnt(MASK_W'(hdrLow[CLS_MASK_W-1:0]));
        end
        OP_INCR: begin
          loadMode = PAY_INCR;
          loadCnt  = hdrLow;
        end
        OP_NONINCR: begin
          loadMode = PAY_FIXED;
          loadCnt  = hdrLow;
        end
        OP_MASK: begin
          loadMode = PAY_MASK;
          loadCnt  = popCnt(hdrLow);
        end
        OP_IMM: begin
          strb.evtFire = 1'b1;
          strb.evtKind = EVT_IMM;
        end
        OP_RESTART: begin
          strb.evtFire = 1'b1;
          strb.evtKind = EVT_RESTART;
        end
        OP_GATHER: begin
          loadMode = PAY_GATHER;
          loadCnt  = CNT_W'(1);
        end
        OP_EXT: begin
          strb.evtFire = 1'b1;
          if (hdrSub == SUB_W'(0))      strb.evtKind = EVT_LOCK_ACQ;
          else if (hdrSub == SUB_W'(1)) strb.evtKind = EVT_LOCK_REL;
          else                          strb.evtKind = EVT_EXT_UNKNOWN;
        end
        default: strb.errFire = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remCnt <= '0;
      mode   <= PAY_INCR;
    end else if (strb.hdrLoad) begin
      remCnt <= loadCnt;
      mode   <= loadMode;
    end else if (strb.payStep || strb.gathAddr) begin
      remCnt <= remCnt - CNT_W'(1);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && accept) |=> (remCnt == $past(remCnt) - CNT_W'(1))); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(remCnt)); // R11
  AST_GATHER_ONE: assert property (@(posedge clk) disable iff (rst)
    strb.gathAddr |=> (remCnt == '0)); // R8
endmodule

// File: rtl/cmd_dec_dp.sv
module cmd_dec_dp
  import cmd_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctlStrb_t           strb,
  input  logic [WORD_W-1:0]  word,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [OFF_W-1:0]   wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic [CLASS_W-1:0] wrClass,
  output logic               evtValid,
  output logic [KIND_W-1:0]  evtKind,
  output logic [OFF_W-1:0]   evtOffset,
  output logic [WORD_W-1:0]  evtData,
  output logic               gathValid,
  output logic [OFF_W-1:0]   gathOffset,
  output logic               gathInsert,
  output logic               gathType,
  output logic [GCNT_W-1:0]  gathCount,
  output logic [WORD_W-1:0]  gathAddr,
  output logic               errPulse
);
  logic [OFF_W-1:0]   curOff, payOff;
  logic [MASK_W-1:0]  curMask;
  logic [CLASS_W-1:0] curClass;
  logic [MIDX_W-1:0]  bitK;
  logic [OFF_W-1:0]   gHdrOff;
  logic               gHdrIns, gHdrType;
  logic [GCNT_W-1:0]  gHdrCnt;
  logic               isSetClass;

  assign bitK       = lowIdx(curMask);
  assign isSetClass = word[WORD_W-1 -: OP_W] == OP_SETCLASS;

  always_comb begin
    case (strb.payMode)
      PAY_MASK: payOff = curOff + OFF_W'(bitK);
      default:  payOff = curOff;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curOff     <= '0;
      curMask    <= '0;
      curClass   <= '0;
      gHdrOff    <= '0;
      gHdrIns    <= 1'b0;
      gHdrType   <= 1'b0;
      gHdrCnt    <= '0;
      wrValid    <= 1'b0;
      wrOffset   <= '0;
      wrData     <= '0;
      wrClass    <= '0;
      evtValid   <= 1'b0;
      evtKind    <= '0;
      evtOffset  <= '0;
      evtData    <= '0;
      gathValid  <= 1'b0;
      gathOffset <= '0;
      gathInsert <= 1'b0;
      gathType   <= 1'b0;
      gathCount  <= '0;
      gathAddr   <= '0;
      errPulse   <= 1'b0;
    end else begin
      evtValid  <= strb.evtFire;
      errPulse  <= strb.errFire;
      gathValid <= strb.gathAddr;

      if (strb.hdrLoad) begin
        curOff   <= word[27:16];
        curMask  <= isSetClass ? MASK_W'(word[CLS_MASK_W-1:0]) : word[MASK_W-1:0];
        gHdrOff  <= word[27:16];
        gHdrIns  <= word[15];
        gHdrType <= word[14];
        gHdrCnt  <= word[GCNT_W-1:0];
      end

      if (strb.classLoad) curClass <= word[15:6];

      if (strb.evtFire) begin
        evtKind <= strb.evtKind;
        case (strb.evtKind)
          EVT_CLASS: begin
            evtOffset <= word[27:16];
            evtData   <= WORD_W'(word[15:6]);
          end
          EVT_IMM: begin
            evtOffset <= word[27:16];
            evtData   <= WORD_W'(word[15:0]);
          end
          EVT_RESTART: begin
            evtOffset <= '0;
            evtData   <= {word[WORD_W-5:0], 4'b0000};
          end
          EVT_LOCK_ACQ, EVT_LOCK_REL: begin
            evtOffset <= '0;
            evtData   <= WORD_W'(word[IDX_W-1:0]);
          end
          default: begin
            evtOffset <= '0;
            evtData   <= word;
          end
        endcase
      end

      if (strb.payStep) begin
        wrValid  <= 1'b1;
        wrOffset <= payOff;
        wrData   <= word;
        wrClass  <= curClass;
        if (strb.payMode == PAY_INCR) curOff <= curOff + OFF_W'(1);
        if (strb.payMode == PAY_MASK) curMask <= curMask & ~(MASK_W'(1) << bitK);
      end else if (wrReady) begin
        wrValid <= 1'b0;
      end

      if (strb.gathAddr) begin
        gathOffset <= gHdrOff;
        gathInsert <= gHdrIns;
        gathType   <= gHdrType;
        gathCount  <= gHdrCnt;
        gathAddr   <= word;
      end
    end
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData) && $stable(wrOffset) && $stable(wrClass))); // R11
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evtValid, gathValid, errPulse})); // R12
  AST_WR_AFTER_PAY: assert property (@(posedge clk) disable iff (rst)
    strb.payStep |=> wrValid); // R12
  AST_MASK_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (strb.payStep && strb.payMode == PAY_MASK) |=>
      ($countones(curMask) == $countones($past(curMask)) - 1)); // R4
  AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.classLoad |=> $stable(curClass)); // R5
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  output logic               inReady,
  input  logic [WORD_W-1:0]  inWord,
  output logic               wrValid,
  input  logic               wrReady,
  output logic [OFF_W-1:0]   wrOffset,
  output logic [WORD_W-1:0]  wrData,
  output logic [CLASS_W-1:0] wrClass,
  output logic               evtValid,
  output logic [KIND_W-1:0]  evtKind,
  output logic [OFF_W-1:0]   evtOffset,
  output logic [WORD_W-1:0]  evtData,
  output logic               gathValid,
  output logic [OFF_W-1:0]   gathOffset,
  output logic               gathInsert,
  output logic               gathType,
  output logic [GCNT_W-1:0]  gathCount,
  output logic [WORD_W-1:0]  gathAddr,
  output logic               errPulse
);
  ctlStrb_t strb;

  cmd_dec_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .hdrOp   (inWord[WORD_W-1 -: OP_W]),
    .hdrSub  (inWord[27:24]),
    .hdrLow  (inWord[MASK_W-1:0]),
    .wrValid (wrValid),
    .wrReady (wrReady),
    .inReady (inReady),
    .strb    (strb)
  );

  cmd_dec_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .word       (inWord),
    .wrReady    (wrReady),
    .wrValid    (wrValid),
    .wrOffset   (wrOffset),
    .wrData     (wrData),
    .wrClass    (wrClass),
    .evtValid   (evtValid),
    .evtKind    (evtKind),
    .evtOffset  (evtOffset),
    .evtData    (evtData),
    .gathValid  (gathValid),
    .gathOffset (gathOffset),
    .gathInsert (gathInsert),
    .gathType   (gathType),
    .gathCount  (gathCount),
    .gathAddr   (gathAddr),
    .errPulse   (errPulse)
  );
endmodule

// File: tb/sim_cmd_stream_decoder.sv
module sim_cmd_stream_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        wrReady = 1'b1;
  logic        inReady, wrValid, evtValid, gathValid, gathInsert, gathType, errPulse;
  logic [11:0] wrOffset, evtOffset, gathOffset;
  logic [31:0] wrData, evtData, gathAddr;
  logic [9:0]  wrClass;
  logic [2:0]  evtKind;
  logic [13:0] gathCount;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_stream_decoder u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .wrValid(wrValid), .wrReady(wrReady), .wrOffset(wrOffset), .wrData(wrData),
    .wrClass(wrClass), .evtValid(evtValid), .evtKind(evtKind), .evtOffset(evtOffset),
    .evtData(evtData), .gathValid(gathValid), .gathOffset(gathOffset),
    .gathInsert(gathInsert), .gathType(gathType), .gathCount(gathCount),
    .gathAddr(gathAddr), .errPulse(errPulse)
  );

  // Port logs, captured mid-cycle
  logic [11:0] wOff [LOG_N];
  logic [31:0] wDat [LOG_N];
  logic [9:0]  wCls [LOG_N];
  logic [2:0]  eKind [LOG_N];
  logic [11:0] eOff [LOG_N];
  logic [31:0] eDat [LOG_N];
  logic [31:0] gInfo [LOG_N];
  logic [31:0] gAdr [LOG_N];
  int wN = 0, eN = 0, gN = 0, errN = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wrValid && wrReady && wN < LOG_N) begin
        wOff[wN] = wrOffset; wDat[wN] = wrData; wCls[wN] = wrClass; wN++;
      end
      if (evtValid && eN < LOG_N) begin
        eKind[eN] = evtKind; eOff[eN] = evtOffset; eDat[eN] = evtData; eN++;
      end
      if (gathValid && gN < LOG_N) begin
        gInfo[gN] = {2'b00, gathOffset, gathInsert, gathType, 2'b00, gathCount};
        gAdr[gN] = gathAddr; gN++;
      end
      if (errPulse) errN++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearLogs();
    wN = 0; eN = 0; gN = 0; errN = 0;
  endtask

  // Called at posedge+1; returns at posedge+1 of the accepting edge
  task automatic sendWord(input logic [31:0] w);
    bit acc;
    acc = 1'b0;
    inValid = 1'b1;
    inWord = w;
    while (!acc) begin
      @(negedge clk);
      acc = inReady;
      @(posedge clk);
      #1;
    end
    inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) begin @(posedge clk); #1; end
  endtask

  task automatic expectWrite(input string tag, input int i, input logic [11:0] off,
                             input logic [31:0] dat, input logic [9:0] cls);
    check({tag, " offset"}, 32'(wOff[i]), 32'(off));
    check({tag, " data"}, wDat[i], dat);
    check({tag, " class"}, 32'(wCls[i]), 32'(cls));
  endtask

  task automatic expectEvt(input string tag, input int i, input logic [2:0] kind,
                           input logic [11:0] off, input logic [31:0] dat);
    check({tag, " kind"}, 32'(eKind[i]), 32'(kind));
    check({tag, " offset"}, 32'(eOff[i]), 32'(off));
    check({tag, " data"}, eDat[i], dat);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 inReady", 32'(inReady), 32'd1);
    check("R1 wrValid", 32'(wrValid), 32'd0);
    check("R1 evtValid", 32'(evtValid), 32'd0);
    check("R1 gathValid", 32'(gathValid), 32'd0);
    check("R1 errPulse", 32'(errPulse), 32'd0);
    @(posedge clk); #1;
  endtask

  task automatic testIncr();
    clearLogs();
    sendWord(32'h1123_0003);
    sendWord(32'hAAAA_0001);
    sendWord(32'hBBBB_0002);
    sendWord(32'hCCCC_0003);
    sendWord(32'h1200_0000);      // R2: count zero, next word is a header
    sendWord(32'h4077_0012);
    drain();
    check("R2 write count", 32'(wN), 32'd3);
    expectWrite("R2 w0 R1 class", 0, 12'h123, 32'hAAAA_0001, 10'h000);
    expectWrite("R2 w1", 1, 12'h124, 32'hBBBB_0002, 10'h000);
    expectWrite("R2 w2", 2, 12'h125, 32'hCCCC_0003, 10'h000);
    check("R2 zero-count event count", 32'(eN), 32'd1);
    expectEvt("R2 header after zero count", 0, 3'd1, 12'h077, 32'h0000_0012);
  endtask

  task automatic testNonIncr();
    clearLogs();
    sendWord(32'h2040_0002);
    sendWord(32'h1111_1111);
    sendWord(32'h2222_2222);
    drain();
    check("R3 write count", 32'(wN), 32'd2);
    expectWrite("R3 w0", 0, 12'h040, 32'h1111_1111, 10'h000);
    expectWrite("R3 w1", 1, 12'h040, 32'h2222_2222, 10'h000);
  endtask

  task automatic testClass();
    clearLogs();
    sendWord(32'h0010_0AA5);       // class 0x2A, offset 0x010, mask 0b100101
    sendWord(32'h0000_00C0);
    sendWord(32'h0000_00C2);
    sendWord(32'h0000_00C5);
    sendWord(32'h1050_0001);
    sendWord(32'h0000_0D00);
    drain();
    check("R5 event count", 32'(eN), 32'd1);
    expectEvt("R5 class event", 0, 3'd0, 12'h010, 32'h0000_002A);
    check("R5 write count", 32'(wN), 32'd4);
    expectWrite("R5 w0", 0, 12'h010, 32'h0000_00C0, 10'h02A);
    expectWrite("R5 w1", 1, 12'h012, 32'h0000_00C2, 10'h02A);
    expectWrite("R5 w2", 2, 12'h015, 32'h0000_00C5, 10'h02A);
    expectWrite("R5 later write", 3, 12'h050, 32'h0000_0D00, 10'h02A);
  endtask

  task automatic testMask();
    clearLogs();
    sendWord(32'h3100_8001);
    sendWord(32'h0000_F000);
    sendWord(32'h0000_F00F);
    sendWord(32'h3200_0000);       // R4: zero mask, no payload
    sendWord(32'h5000_0001);
    drain();
    check("R4 write count", 32'(wN), 32'd2);
    expectWrite("R4 w0", 0, 12'h100, 32'h0000_F000, 10'h02A);
    expectWrite("R4 w1", 1, 12'h10F, 32'h0000_F00F, 10'h02A);
    check("R4 zero-mask event count", 32'(eN), 32'd1);
    expectEvt("R4 header after zero mask", 0, 3'd2, 12'h000, 32'h0000_0010);
  endtask

  task automatic testImmRestart();
    clearLogs();
    sendWord(32'h4055_BEEF);
    sendWord(32'h5123_4567);
    drain();
    check("R6 R7 event count", 32'(eN), 32'd2);
    expectEvt("R6 immediate", 0, 3'd1, 12'h055, 32'h0000_BEEF);
    expectEvt("R7 restart", 1, 3'd2, 12'h000, 32'h1234_5670);
    check("R6 no write", 32'(wN), 32'd0);
  endtask

  task automatic testGather();
    clearLogs();
    sendWord(32'h6020_C00A);
    sendWord(32'hDEAD_0000);
    sendWord(32'h6030_0005);
    sendWord(32'h0000_1000);
    drain();
    check("R8 gather count", 32'(gN), 32'd2);
    check("R8 no write", 32'(wN), 32'd0);
    check("R8 g0 fields", gInfo[0], {2'b00, 12'h020, 1'b1, 1'b1, 2'b00, 14'h000A});
    check("R8 g0 addr", gAdr[0], 32'hDEAD_0000);
    check("R8 g1 fields", gInfo[1], {2'b00, 12'h030, 1'b0, 1'b0, 2'b00, 14'h0005});
    check("R8 g1 addr", gAdr[1], 32'h0000_1000);
  endtask

  task automatic testExtended();
    clearLogs();
    sendWord(32'hE000_0007);
    sendWord(32'hE100_00FF);
    sendWord(32'hE200_1234);
    drain();
    check("R9 event count", 32'(eN), 32'd3);
    expectEvt("R9 acquire", 0, 3'd3, 12'h000, 32'h0000_0007);
    expectEvt("R9 release", 1, 3'd4, 12'h000, 32'h0000_00FF);
    expectEvt("R9 unknown", 2, 3'd5, 12'h000, 32'hE200_1234);
  endtask

  task automatic testBadOpcode();
    clearLogs();
    sendWord(32'h7000_0003);
    @(negedge clk);
    check("R10 pulse high", 32'(errPulse), 32'd1);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(errPulse), 32'd0);
    @(posedge clk); #1;
    sendWord(32'hF123_0002);
    sendWord(32'h4001_0002);       // must decode as header
    drain();
    check("R10 error count", 32'(errN), 32'd2);
    check("R10 no write", 32'(wN), 32'd0);
    check("R10 event count", 32'(eN), 32'd1);
    expectEvt("R10 header after bad", 0, 3'd1, 12'h001, 32'h0000_0002);
  endtask

  task automatic testStall();
    clearLogs();
    wrReady = 1'b0;
    sendWord(32'h1300_0002);
    sendWord(32'h0000_5A01);
    inValid = 1'b1;
    inWord = 32'h0000_5A02;
    repeat (3) begin
      @(negedge clk);
      check("R11 inReady low", 32'(inReady), 32'd0);
      check("R11 data held", wrData, 32'h0000_5A01);
      check("R11 offset held", 32'(wrOffset), 32'h300);
    end
    @(posedge clk); #1;
    wrReady = 1'b1;
    sendWord(32'h0000_5A02);
    drain();
    check("R11 write count", 32'(wN), 32'd2);
    expectWrite("R11 w0", 0, 12'h300, 32'h0000_5A01, 10'h02A);
    expectWrite("R11 w1", 1, 12'h301, 32'h0000_5A02, 10'h02A);
  endtask

  task automatic testLatency();
    sendWord(32'h4011_0001);
    @(negedge clk);
    check("R12 event next cycle", 32'(evtValid), 32'd1);
    @(negedge clk);
    check("R12 event one cycle", 32'(evtValid), 32'd0);
    @(posedge clk); #1;
    sendWord(32'h1111_0001);
    @(negedge clk);
    check("R12 header no write", 32'(wrValid), 32'd0);
    @(posedge clk); #1;
    sendWord(32'h0000_0777);
    @(negedge clk);
    check("R12 write next cycle", 32'(wrValid), 32'd1);
    @(posedge clk); #1;
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    testReset();
    testIncr();
    testNonIncr();
    testClass();
    testMask();
    testImmRestart();
    testGather();
    testExtended();
    testBadOpcode();
    testStall();
    testLatency();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule